// File: doc/BRIEF.md
# Accumulator-Stack Execution Core

A 16-bit processor core that executes one instruction per clock: an 8-bit opcode and a 16-bit argument, fetched externally at the address the core presents on its program counter output. All data movement goes through a single temporary register. From that register the program can reach a small register file made up of the program counter, the stack pointer and four general registers. A data stack lives in external memory and is addressed by a wrapping stack pointer.

The data memory port is synchronous. A write strobe stores data in the same cycle it is raised, and a read strobe returns data on the following cycle. Because of the read latency, the stack peek instruction takes two cycles; all other instructions take one. Address decoding of the memory map is done outside the core. When the program counter equals all ones, the core stops: no state changes and no strobes are raised. A program halts by writing 0xFFFF to the program counter.

Top module: `stack_core`

## Requirements
- R1: While the program counter equals 0xFFFF, `halted` is 1, no register changes and neither memory strobe is raised.
- R2: Opcode 0x00, and every opcode other than 0x01 to 0x06 and 0x08, changes nothing except advancing the program counter by one.
- R3: Opcode 0x01 writes the argument to memory at SP, then increments SP modulo 2^16.
- R4: Opcode 0x02 decrements SP modulo 2^16, then writes zero to memory at the new SP.
- R5: Opcode 0x03 loads the argument into the temp register.
- R6: Opcode 0x04 loads temp from the register selected by the argument, using 0 = PC (the instruction's own address), 1 = SP, 2 = A, 3 = B, 4 = C and 5 = D. Any other index reads as zero.
- R7: Opcode 0x05 raises the read strobe at address SP-1, leaves SP unchanged, and on the next cycle loads temp from the read data. The program counter advances only after that second cycle.
- R8: Opcode 0x06 copies temp into the register selected by the argument, using the R6 encoding. A write to any other index is ignored.
- R9: Opcode 0x06 with index 0 makes temp the next program counter, and the sequential increment is suppressed.
- R10: Opcode 0x08 writes temp to memory at SP, then increments SP modulo 2^16.
- R11: Reset clears PC, SP, temp and A to D to zero.
- R12: Each write strobe lasts exactly the one cycle of the instruction that raises it, and the two strobes are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | output | 16 | Program counter, the fetch address |
| op | input | 8 | Opcode of the instruction at `pc` |
| arg | input | 16 | Argument of the instruction at `pc` |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 16 | Data memory write data |
| mem_wr | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe; data is returned on the next cycle |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| halted | output | 1 | High while the program counter equals 0xFFFF |

## Verification
A register write to index 0 and the sequential program-counter increment fall in the same cycle. The write must win. The bench provokes this with a jump over an instruction that would push a marker value. The marker must never appear on the write port, and the next push must store the jump target. Halting is provoked through the same path: a jump to 0xFFFF must stop the core. Every unused program location pushes a marker, so any further write is reported.

// File: rtl/stack_core.sv
module stack_core #(
  parameter int DW = 16,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] pc,
  input  logic [OW-1:0] op,
  input  logic [DW-1:0] arg,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted
);
  localparam logic [OW-1:0] OP_NOP  = OW'(0);
  localparam logic [OW-1:0] OP_PSHA = OW'(1);
  localparam logic [OW-1:0] OP_POP  = OW'(2);
  localparam logic [OW-1:0] OP_LDA  = OW'(3);
  localparam logic [OW-1:0] OP_GETR = OW'(4);
  localparam logic [OW-1:0] OP_PEEK = OW'(5);
  localparam logic [OW-1:0] OP_SETR = OW'(6);
  localparam logic [OW-1:0] OP_PSHT = OW'(8);
  localparam logic [DW-1:0] STOP_PC = '1;
  localparam logic [DW-1:0] ONE     = DW'(1);

  logic [DW-1:0] pc_q, sp_q, tmp_q, ra_q, rb_q, rc_q, rd_q;
  logic [DW-1:0] sp_dec, sel_val;
  logic          wait_q, run, exec;

  assign pc     = pc_q;
  assign halted = (pc_q == STOP_PC);
  assign run    = !halted;
  assign exec   = run && !wait_q;
  assign sp_dec = sp_q - ONE;

  always_comb begin
    case (arg)
      DW'(0):  sel_val = pc_q;
      DW'(1):  sel_val = sp_q;
      DW'(2):  sel_val = ra_q;
      DW'(3):  sel_val = rb_q;
      DW'(4):  sel_val = rc_q;
      DW'(5):  sel_val = rd_q;
      default: sel_val = '0;
    endcase
  end

  always_comb begin
    mem_wr    = 1'b0;
    mem_rd    = 1'b0;
    mem_addr  = sp_q;
    mem_wdata = '0;
    if (exec) begin
      case (op)
        OP_PSHA: begin mem_wr = 1'b1; mem_wdata = arg; end
        OP_POP:  begin mem_wr = 1'b1; mem_addr = sp_dec; end
        OP_PEEK: begin mem_rd = 1'b1; mem_addr = sp_dec; end
        OP_PSHT: begin mem_wr = 1'b1; mem_wdata = tmp_q; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0; sp_q <= '0; tmp_q <= '0; wait_q <= 1'b0;
      ra_q <= '0; rb_q <= '0; rc_q <= '0; rd_q <= '0;
    end else if (run) begin
      if (wait_q) begin
        tmp_q  <= mem_rdata;
        wait_q <= 1'b0;
        pc_q   <= pc_q + ONE;
      end else begin
        pc_q <= pc_q + ONE;
        case (op)
          OP_PSHA, OP_PSHT: sp_q <= sp_q + ONE;
          OP_POP:  sp_q  <= sp_dec;
          OP_LDA:  tmp_q <= arg;
          OP_GETR: tmp_q <= sel_val;
          OP_PEEK: begin wait_q <= 1'b1; pc_q <= pc_q; end
          OP_SETR: begin
            case (arg)
              DW'(0):  pc_q <= tmp_q;
              DW'(1):  sp_q <= tmp_q;
              DW'(2):  ra_q <= tmp_q;
              DW'(3):  rb_q <= tmp_q;
              DW'(4):  rc_q <= tmp_q;
              DW'(5):  rd_q <= tmp_q;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  assert_halt_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_wr && !mem_rd));
  assert_halt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc) && $stable(sp_q) && $stable(tmp_q)));
  assert_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_NOP) |=> (pc_q == $past(pc_q) + ONE && $stable(sp_q) && $stable(tmp_q)));
  assert_push_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_PSHA) |=> (sp_q == $past(sp_q) + ONE));
  assert_pop_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_POP) |=> (sp_q == $past(sp_q) - ONE && $past(mem_wdata) == '0));
  assert_peek_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_PEEK) |=> ($stable(pc_q) && $stable(sp_q) && !mem_rd && !mem_wr));
  assert_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_SETR && arg == '0) |=> (pc_q == $past(tmp_q)));
  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));
endmodule

// File: tb/test_stack_core.sv
`timescale 1ns/1ps
module test_stack_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pc, arg, mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  op;
  logic        mem_wr, mem_rd, halted;

  logic [7:0]  rom_op [64];
  logic [15:0] rom_arg[64];
  logic [15:0] mem    [256];
  int          ptr = 0;
  int          checks = 0, errors = 0;
  logic [15:0] esp = 16'h0, etmp = 16'h0;
  logic [15:0] qa[$], qd[$];
  string       qs[$];

  always #2.5 clk = ~clk;

  assign op  = rom_op[pc[5:0]];
  assign arg = rom_arg[pc[5:0]];

  stack_core i_stack_core (
    .clk(clk), .rst_n(rst_n), .pc(pc), .op(op), .arg(arg),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .halted(halted));

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      if (qa.size() == 0) begin
        check(1'b0, "R1/R9 unexpected write", mem_wdata, 16'h0);
      end else begin
        logic [15:0] ea, ed;
        string t;
        ea = qa.pop_front(); ed = qd.pop_front(); t = qs.pop_front();
        check(mem_addr == ea, {t, " addr"}, mem_addr, ea);
        check(mem_wdata == ed, {t, " data"}, mem_wdata, ed);
      end
    end
    if (rst_n) check(!(mem_wr && mem_rd), "R12 strobes", {14'h0, mem_wr, mem_rd}, 16'h0);
  end

  task automatic ins(input logic [7:0] o, input logic [15:0] a);
    rom_op[ptr] = o; rom_arg[ptr] = a; ptr++;
  endtask
  task automatic expw(input logic [15:0] a, input logic [15:0] d, input string t);
    qa.push_back(a); qd.push_back(d); qs.push_back(t);
  endtask
  task automatic push_arg(input logic [15:0] a, input string t);
    ins(8'h01, a); expw(esp, a, t); esp = esp + 16'h1;
  endtask
  task automatic push_tmp(input string t);
    ins(8'h08, 16'h0); expw(esp, etmp, t); esp = esp + 16'h1;
  endtask
  task automatic pop(input string t);
    ins(8'h02, 16'h0); esp = esp - 16'h1; expw(esp, 16'h0, t);
  endtask
  task automatic ld(input logic [15:0] a);
    ins(8'h03, a); etmp = a;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin rom_op[i] = 8'h01; rom_arg[i] = 16'h4242; end
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    mem_rdata = 16'h0;

    push_tmp("R11 temp/sp reset");
    ins(8'h04, 16'd2); etmp = 16'h0; push_tmp("R11 reg A reset");
    ld(16'h1234); push_tmp("R5/R10 push temp");
    push_arg(16'h00AB, "R3 push arg");
    ins(8'h05, 16'h0); etmp = 16'h00AB;
    push_tmp("R7 peek");
    pop("R4 pop clears");
    ins(8'h06, 16'd2);
    ld(16'h5555); ins(8'h06, 16'd7);
    ins(8'h04, 16'd7); etmp = 16'h0; push_tmp("R6/R8 bad index");
    ins(8'h04, 16'd2); etmp = 16'h00AB; push_tmp("R8 reg A write");
    etmp = 16'(ptr); ins(8'h04, 16'd0); push_tmp("R6 PC read");
    etmp = esp; ins(8'h04, 16'd1); push_tmp("R6 SP read");
    ins(8'h00, 16'h0); ins(8'h07, 16'h9999); ins(8'h09, 16'h0);
    push_tmp("R2 nop and unimplemented");
    ld(16'(ptr + 3)); ins(8'h06, 16'd0); ins(8'h01, 16'hDEAD);
    push_tmp("R9 jump target");
    ld(16'hBEEF); ins(8'h06, 16'd5); ld(16'hC0DE); ins(8'h06, 16'd4);
    ins(8'h04, 16'd5); etmp = 16'hBEEF; push_tmp("R8 reg D");
    ins(8'h04, 16'd4); etmp = 16'hC0DE; push_tmp("R8 reg C");
    ld(16'hFFFF); ins(8'h06, 16'd1); esp = 16'hFFFF;
    push_arg(16'h0077, "R3 push at top");
    push_arg(16'h0088, "R3 push wrapped");
    pop("R4 pop at zero");
    pop("R4 pop wraps");
    push_tmp("R10 push at top");
    ld(16'hFFFF); ins(8'h06, 16'd0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pc == 16'h0, "R11 pc reset", pc, 16'h0);
    check(halted == 1'b0, "R11 not halted", {15'h0, halted}, 16'h0);
    rst_n = 1'b1;

    begin
      int n;
      n = 0;
      while (!halted && n < 2000) begin @(negedge clk); n++; end
      check(halted == 1'b1, "R1 watchdog: halt reached", {15'h0, halted}, 16'h1);
    end
    repeat (10) @(negedge clk);
    check(pc == 16'hFFFF, "R1 pc held", pc, 16'hFFFF);
    check(!mem_wr && !mem_rd, "R1 quiet", {14'h0, mem_wr, mem_rd}, 16'h0);
    check(qa.size() == 0, "R12 all writes seen", 16'(qa.size()), 16'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule